// File: doc/BRIEF.md
# Forced Role Swap Controller

This block sequences a request to move a connector port into a chosen power role, sink or source. The typical case is two dual-role ports that attached in the wrong roles. One side forces the opposite role, and the port then detaches. It presents the requested role to the attach detector and waits a programmable number of timer ticks for the detector to report a good attach.

If the attach arrives in time, the new role is kept and a sticky success flag is raised. If the window runs out first, the port returns to the role it held before the request and a sticky failure flag is raised. A request for the role the port already holds succeeds at once, with no detach.

The detector and the analog switching sit outside this block. It only drives the role selection and a detach pulse, and it takes back an attach-good indication and a periodic tick.

Top module: `role_swap_ctrl`

## Requirements
- R1: After reset, role_o is the RESET_ROLE parameter (default 0 = sink), detach_o is 0, and both interrupt flags are 0.
- R2: Role encoding on role_o is 0 = sink and 1 = source. force_sink_i requests 0 and force_source_i requests 1. When both are high in the same cycle, the sink request is taken.
- R3: When the port is idle and a command names a role other than the present one, detach_o is high for exactly the one cycle after the edge that samples the command. At the following edge, role_o changes to the requested role.
- R4: An attach_ok_i sampled during the trial commits the requested role. irq_succ_o is high from the second clock edge after that sample, and role_o keeps the requested role.
- R5: During the trial, every tick_i sampled without attach_ok_i is counted. The edge that samples tick number N ends the trial, where N = trial_limit_i and a limit of 0 counts as 1. At the next edge, role_o returns to the role held before the request and irq_fail_o is set.
- R6: When attach_ok_i and tick_i are sampled in the same trial cycle, the attach wins and the sequence ends in success, even on the final tick.
- R7: A command naming the role already held sets irq_succ_o at the edge that samples it. detach_o stays 0 and role_o does not change.
- R8: Force commands that arrive while a sequence is in progress are ignored. They change neither role_o, detach_o nor the outcome.
- R9: Each flag stays set until its own clear strobe (clr_succ_i or clr_fail_i) is sampled. When a set and a clear of the same flag meet in one cycle, the set wins.
- R10: The success flag and the failure flag are never raised at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| force_sink_i | input | 1 | Request the sink role (one-cycle strobe) |
| force_source_i | input | 1 | Request the source role (one-cycle strobe) |
| attach_ok_i | input | 1 | Detector reports an attach in the presented role |
| tick_i | input | 1 | Timer tick used to measure the trial window |
| trial_limit_i | input | CNT_W | Number of ticks allowed for the trial (0 treated as 1) |
| clr_succ_i | input | 1 | Write-one-to-clear strobe for the success flag |
| clr_fail_i | input | 1 | Write-one-to-clear strobe for the failure flag |
| role_o | output | 1 | Role presented to the detector (0 sink, 1 source) |
| detach_o | output | 1 | One-cycle detach request to the detector |
| irq_succ_o | output | 1 | Sticky success interrupt flag |
| irq_fail_o | output | 1 | Sticky failure interrupt flag |

## Verification
Every result has a fixed latency from its stimulus:
- Detach appears one edge after the command, and the new role one edge later.
- Success appears two edges after the attach sample, and a same-role success one edge after the command.
- Failure and rollback appear two edges after the final tick.

The driver records each expected outcome in a queue, tagged with the exact cycle it is due. The monitor samples on the falling edge and pops an entry whenever a flag rises. It compares the cycle, the flag kind and role_o, so an outcome that is early, late, missing or extra is reported. The detach pulse and the ignored commands are checked directly at the cycles where they would show.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DETACH = 3'd1,
    ST_TRY    = 3'd2,
    ST_COMMIT = 3'd3,
    ST_REVERT = 3'd4
  } swap_state_e;

  typedef enum logic {
    ROLE_SINK   = 1'b0,
    ROLE_SOURCE = 1'b1
  } port_role_e;

  // Sink request wins over a simultaneous source request.
  function automatic port_role_e pick_request(input logic want_sink, input logic want_source);
    return (want_sink || !want_source) ? ROLE_SINK : ROLE_SOURCE;
  endfunction

  // True once the tick count reaches the effective limit (0 counts as 1).
  function automatic logic window_spent(input int unsigned ticks_seen, input int unsigned limit);
    int unsigned eff;
    eff = (limit == 0) ? 1 : limit;
    return ticks_seen >= eff;
  endfunction

endpackage

// File: rtl/rfs_trial_timer.sv
module rfs_trial_timer
  import rfs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick_in,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      next_seen;

  assign next_seen = 32'(cnt_q) + 32'd1;
  assign expired   = tick_in && window_spent(next_seen, 32'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (tick_in && !expired) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rfs_swap_seq.sv
module rfs_swap_seq
  import rfs_pkg::*;
#(
  parameter port_role_e RESET_ROLE = ROLE_SINK
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        force_sink,
  input  logic        force_source,
  input  logic        attach_ok,
  input  logic        window_expired,
  output swap_state_e state,
  output port_role_e  cur_role,
  output port_role_e  target_role,
  output port_role_e  saved_role,
  output logic        ev_accept,
  output logic        ev_instant,
  output logic        ev_commit,
  output logic        ev_revert,
  output logic        trial_active
);

  swap_state_e state_d;
  port_role_e  req_role;
  logic        any_cmd;
  logic        idle;

  assign any_cmd      = force_sink || force_source;
  assign req_role     = pick_request(force_sink, force_source);
  assign idle         = (state == ST_IDLE);
  assign ev_instant   = idle && any_cmd && (req_role == cur_role);
  assign ev_accept    = idle && any_cmd && (req_role != cur_role);
  assign trial_active = (state == ST_TRY);
  assign ev_commit    = (state == ST_COMMIT);
  assign ev_revert    = (state == ST_REVERT);

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:   if (ev_accept) state_d = ST_DETACH;
      ST_DETACH: state_d = ST_TRY;
      ST_TRY: begin
        if (attach_ok)           state_d = ST_COMMIT;
        else if (window_expired) state_d = ST_REVERT;
      end
      ST_COMMIT: state_d = ST_IDLE;
      ST_REVERT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cur_role    <= RESET_ROLE;
      target_role <= RESET_ROLE;
      saved_role  <= RESET_ROLE;
    end else begin
      state <= state_d;
      if (ev_accept) begin
        target_role <= req_role;
        saved_role  <= cur_role;
      end
      if (state == ST_DETACH) cur_role <= target_role;
      if (ev_revert)          cur_role <= saved_role;
    end
  end

endmodule

// File: rtl/rfs_irq_flags.sv
module rfs_irq_flags #(
  parameter int N_FLAGS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] set_in,
  input  logic [N_FLAGS-1:0] clr_in,
  output logic [N_FLAGS-1:0] flag_q
);

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q[i] <= 1'b0;
      else if (set_in[i]) flag_q[i] <= 1'b1;
      else if (clr_in[i]) flag_q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/role_swap_ctrl.sv
module role_swap_ctrl
  import rfs_pkg::*;
#(
  parameter int         CNT_W      = 8,
  parameter port_role_e RESET_ROLE = ROLE_SINK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_sink_i,
  input  logic             force_source_i,
  input  logic             attach_ok_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] trial_limit_i,
  input  logic             clr_succ_i,
  input  logic             clr_fail_i,
  output logic             role_o,
  output logic             detach_o,
  output logic             irq_succ_o,
  output logic             irq_fail_o
);

  localparam int IDX_SUCC = 0;
  localparam int IDX_FAIL = 1;
  localparam int N_FLAGS  = 2;

  swap_state_e state;
  port_role_e  cur_role;
  port_role_e  target_role;
  port_role_e  saved_role;
  logic        ev_accept;
  logic        ev_instant;
  logic        ev_commit;
  logic        ev_revert;
  logic        trial_active;
  logic        ev_expire;
  logic        counted_tick;
  logic        succ_set;
  logic        fail_set;
  logic        busy;
  logic [N_FLAGS-1:0] flag_set;
  logic [N_FLAGS-1:0] flag_clr;
  logic [N_FLAGS-1:0] flag_q;

  assign counted_tick = tick_i && trial_active && !attach_ok_i;

  rfs_swap_seq #(.RESET_ROLE(RESET_ROLE)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .force_sink     (force_sink_i),
    .force_source   (force_source_i),
    .attach_ok      (attach_ok_i),
    .window_expired (ev_expire),
    .state          (state),
    .cur_role       (cur_role),
    .target_role    (target_role),
    .saved_role     (saved_role),
    .ev_accept      (ev_accept),
    .ev_instant     (ev_instant),
    .ev_commit      (ev_commit),
    .ev_revert      (ev_revert),
    .trial_active   (trial_active)
  );

  rfs_trial_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state == ST_DETACH),
    .tick_in (counted_tick),
    .limit   (trial_limit_i),
    .expired (ev_expire)
  );

  assign succ_set = ev_instant || ev_commit;
  assign fail_set = ev_revert;

  assign flag_set[IDX_SUCC] = succ_set;
  assign flag_set[IDX_FAIL] = fail_set;
  assign flag_clr[IDX_SUCC] = clr_succ_i;
  assign flag_clr[IDX_FAIL] = clr_fail_i;

  rfs_irq_flags #(.N_FLAGS(N_FLAGS)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_in (flag_set),
    .clr_in (flag_clr),
    .flag_q (flag_q)
  );

  assign busy       = (state != ST_IDLE);
  assign role_o     = cur_role;
  assign detach_o   = (state == ST_DETACH);
  assign irq_succ_o = flag_q[IDX_SUCC];
  assign irq_fail_o = flag_q[IDX_FAIL];

endmodule

// File: rtl/rfs_swap_checker.sv
module rfs_swap_checker (
  input logic clk,
  input logic rst_n,
  input logic clr_succ_i,
  input logic clr_fail_i,
  input logic role_o,
  input logic detach_o,
  input logic irq_succ_o,
  input logic irq_fail_o,
  input logic ev_commit,
  input logic ev_revert,
  input logic ev_instant,
  input logic succ_set,
  input logic fail_set,
  input logic busy,
  input logic saved_role,
  input logic target_role
);

  p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(succ_set && fail_set));

  p_detach_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    detach_o |=> !detach_o);

  p_detach_swaps_role_r3: assert property (@(posedge clk) disable iff (!rst_n)
    detach_o |=> (role_o != $past(role_o)));

  p_commit_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |=> irq_succ_o);

  p_revert_restores_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_revert |=> (irq_fail_o && role_o == $past(saved_role)));

  p_instant_no_detach_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_instant |=> (!detach_o && irq_succ_o && $stable(role_o)));

  p_target_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(target_role));

  p_succ_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_succ_o && !clr_succ_i) |=> irq_succ_o);

  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_fail_o && !clr_fail_i) |=> irq_fail_o);

endmodule

bind role_swap_ctrl rfs_swap_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_succ_i  (clr_succ_i),
  .clr_fail_i  (clr_fail_i),
  .role_o      (role_o),
  .detach_o    (detach_o),
  .irq_succ_o  (irq_succ_o),
  .irq_fail_o  (irq_fail_o),
  .ev_commit   (ev_commit),
  .ev_revert   (ev_revert),
  .ev_instant  (ev_instant),
  .succ_set    (succ_set),
  .fail_set    (fail_set),
  .busy        (busy),
  .saved_role  (saved_role),
  .target_role (target_role)
);

// File: tb/role_swap_ctrl_tb.sv
module role_swap_ctrl_tb;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             force_sink_i = 1'b0;
  logic             force_source_i = 1'b0;
  logic             attach_ok_i = 1'b0;
  logic             tick_i = 1'b0;
  logic [CNT_W-1:0] trial_limit_i = '0;
  logic             clr_succ_i = 1'b0;
  logic             clr_fail_i = 1'b0;
  logic             role_o;
  logic             detach_o;
  logic             irq_succ_o;
  logic             irq_fail_o;

  role_swap_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .force_sink_i   (force_sink_i),
    .force_source_i (force_source_i),
    .attach_ok_i    (attach_ok_i),
    .tick_i         (tick_i),
    .trial_limit_i  (trial_limit_i),
    .clr_succ_i     (clr_succ_i),
    .clr_fail_i     (clr_fail_i),
    .role_o         (role_o),
    .detach_o       (detach_o),
    .irq_succ_o     (irq_succ_o),
    .irq_fail_o     (irq_fail_o)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct {
    int    due;
    bit    succ;
    bit    role;
    string req;
  } outcome_t;

  outcome_t exp_q[$];

  task automatic check_eq(string req, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic expect_outcome(int due, bit succ, bit role, string req);
    outcome_t o;
    o.due = due; o.succ = succ; o.role = role; o.req = req;
    exp_q.push_back(o);
  endtask

  task automatic take(bit succ);
    outcome_t o;
    if (exp_q.size() == 0) begin
      check_eq(succ ? "R4" : "R5", "unexpected flag rise", 1, 0);
    end else begin
      o = exp_q.pop_front();
      check_eq(o.req, "outcome kind (1=success)", int'(succ), int'(o.succ));
      check_eq(o.req, "outcome cycle", cyc, o.due);
      check_eq(o.req, "role at outcome", int'(role_o), int'(o.role));
    end
  endtask

  // Monitor: scoreboard pops on each flag rise
  bit prev_s = 0;
  bit prev_f = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_succ_o && !prev_s && irq_fail_o && !prev_f)
        check_eq("R10", "both flags rose together", 1, 0);
      if (irq_succ_o && !prev_s) take(1'b1);
      if (irq_fail_o && !prev_f) take(1'b0);
    end
    prev_s = irq_succ_o;
    prev_f = irq_fail_o;
  end

  task automatic nedge(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic clear_succ();
    clr_succ_i = 1'b1; nedge(); clr_succ_i = 1'b0;
    check_eq("R9", "succ after clear", int'(irq_succ_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    nedge(3);
    // R1 reset state
    check_eq("R1", "role_o in reset", int'(role_o), 0);
    check_eq("R1", "detach_o in reset", int'(detach_o), 0);
    check_eq("R1", "irq_succ_o in reset", int'(irq_succ_o), 0);
    check_eq("R1", "irq_fail_o in reset", int'(irq_fail_o), 0);
    rst_n = 1'b1;
    nedge(2);

    // R3/R4: sink -> source, attach arrives during trial
    trial_limit_i = 8'd5;
    force_source_i = 1'b1; nedge(); force_source_i = 1'b0;
    check_eq("R3", "detach pulse", int'(detach_o), 1);
    check_eq("R3", "role during detach", int'(role_o), 0);
    nedge();
    check_eq("R3", "detach ended", int'(detach_o), 0);
    check_eq("R3", "role presented", int'(role_o), 1);
    nedge(2);
    attach_ok_i = 1'b1;
    expect_outcome(cyc + 2, 1'b1, 1'b1, "R4");
    nedge(); attach_ok_i = 1'b0;
    nedge(4);
    check_eq("R4", "role kept", int'(role_o), 1);
    check_eq("R9", "succ still set", int'(irq_succ_o), 1);
    clear_succ();

    // R5/R8: source -> sink times out after 3 ticks, a mid-trial command is ignored
    trial_limit_i = 8'd3;
    force_sink_i = 1'b1; nedge(); force_sink_i = 1'b0;
    check_eq("R3", "detach pulse", int'(detach_o), 1);
    nedge();
    check_eq("R3", "role presented", int'(role_o), 0);
    force_source_i = 1'b1; nedge(); force_source_i = 1'b0;
    check_eq("R8", "role after ignored command", int'(role_o), 0);
    check_eq("R8", "no detach from ignored command", int'(detach_o), 0);
    for (int k = 0; k < 3; k++) begin
      tick_i = 1'b1;
      if (k == 2) expect_outcome(cyc + 2, 1'b0, 1'b1, "R5");
      nedge(); tick_i = 1'b0;
      nedge();
    end
    check_eq("R5", "role restored", int'(role_o), 1);
    check_eq("R5", "fail flag", int'(irq_fail_o), 1);
    check_eq("R5", "no success", int'(irq_succ_o), 0);
    nedge(3);
    check_eq("R9", "fail still set", int'(irq_fail_o), 1);
    clr_fail_i = 1'b1; nedge(); clr_fail_i = 1'b0;
    check_eq("R9", "fail after clear", int'(irq_fail_o), 0);

    // R7: same-role request
    force_source_i = 1'b1;
    expect_outcome(cyc + 1, 1'b1, 1'b1, "R7");
    nedge(); force_source_i = 1'b0;
    check_eq("R7", "no detach", int'(detach_o), 0);
    check_eq("R7", "role unchanged", int'(role_o), 1);
    nedge();
    check_eq("R7", "still no detach", int'(detach_o), 0);
    clear_succ();

    // R2/R6: both commands pick sink; attach and final tick together
    trial_limit_i = 8'd1;
    force_sink_i = 1'b1; force_source_i = 1'b1;
    nedge(); force_sink_i = 1'b0; force_source_i = 1'b0;
    check_eq("R2", "detach for sink request", int'(detach_o), 1);
    nedge();
    check_eq("R2", "sink presented", int'(role_o), 0);
    attach_ok_i = 1'b1; tick_i = 1'b1;
    expect_outcome(cyc + 2, 1'b1, 1'b0, "R6");
    nedge(); attach_ok_i = 1'b0; tick_i = 1'b0;
    nedge(3);
    check_eq("R6", "role kept", int'(role_o), 0);
    check_eq("R6", "no failure", int'(irq_fail_o), 0);
    clear_succ();

    // R9: set and clear in the same cycle
    force_sink_i = 1'b1; clr_succ_i = 1'b1;
    expect_outcome(cyc + 1, 1'b1, 1'b0, "R9");
    nedge(); force_sink_i = 1'b0; clr_succ_i = 1'b0;
    check_eq("R9", "set wins over clear", int'(irq_succ_o), 1);
    clear_succ();

    // R5: limit of zero acts as one tick
    trial_limit_i = 8'd0;
    force_source_i = 1'b1; nedge(); force_source_i = 1'b0;
    nedge();
    check_eq("R3", "source presented", int'(role_o), 1);
    tick_i = 1'b1;
    expect_outcome(cyc + 2, 1'b0, 1'b0, "R5");
    nedge(); tick_i = 1'b0;
    nedge();
    check_eq("R5", "zero limit fail", int'(irq_fail_o), 1);
    check_eq("R5", "zero limit role restored", int'(role_o), 0);
    nedge(3);

    check_eq("R4", "outcomes left pending", exp_q.size(), 0);
    finished = 1;
    summary();
    $finish;
  end

endmodule